// File: doc/BRIEF.md
# Five-Pin GPIO Port with Bus-Clock Output

This block is a small memory-mapped general-purpose I/O port with five bidirectional pins. Software reaches it through a plain register bus: an address, a write strobe, write data and combinational read data. A data register holds one output latch bit for each pin. A direction register holds one output-enable bit for each pin, plus one control bit that sends the bus clock out on pin 2.

Every pin is in one of three pin modes: PM_INPUT (driver off), PM_OUTPUT (drives its latch bit) or PM_CLOCK (pin 2 only, drives the bus clock). The clock-out control is a two-state machine. CKO_OFF is the reset state. A direction-register write with bit 7 set moves it to CKO_DRIVE. A direction-register write with bit 7 clear, or a reset, moves it back to CKO_OFF. Any other cycle holds the current state. Pin inputs pass through a two-flop synchronizer before they can be read.

The latch is never reset. Software can therefore load it before it switches a pin to output, and the pin starts driving the intended level with no glitch.

Top module: `gpio_clkout_port`

## Requirements
- R1: A write at address 0x02 loads wdata[4:0] into the output latch at the next rising edge, whatever the direction settings. pin_out[i] carries latch bit i for every pin that is not in clock mode.
- R2: Reset leaves the five output latch bits unchanged, so pin_out keeps the latch value through reset.
- R3: A write at address 0x06 loads wdata[4:0] into the direction bits. pin_oe[i] is 1 exactly when direction bit i is 1 (pin 2 excepted while clock-out is on). Reading 0x06 returns the direction bits in [4:0].
- R4: Reset clears all direction bits and the clock-out enable, so every pin_oe bit is 0 during and after reset.
- R5: Bit 7 of address 0x06 is the clock-out enable. It is written from wdata[7] on any write to 0x06 and reads back in rd_data[7].
- R6: While the clock-out enable is 1, pin 2 has pin_oe[2]=1 and pin_out[2] equal to the bus clock (low in the low phase, high in the high phase), and direction bit 2 has no effect. The other pins behave as R1 and R3 state.
- R7: Reading 0x06 returns 0 in bits 6:5. Reading 0x02 returns 0 in bits 7:5.
- R8: Reading 0x02 returns, for each pin, the latch bit when the pin drives (direction 1 or clock mode), and otherwise the synchronized pin_in level.
- R9: A change on pin_in appears in the 0x02 readback after exactly two rising clock edges, not after one.
- R10: Reads of any address other than 0x02 and 0x06 return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the source driven out on pin 2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| pin_in | input | 5 | Pad input levels (asynchronous) |
| pin_out | output | 5 | Pad output values |
| pin_oe | output | 5 | Pad output enables, 1 = drive |

## Verification
A wrong direction bit or clock-out state shows at pin_oe in the cycle after the write that set it, and in the 0x06 readback at once. A corrupted latch shows on pin_out right away, even on pins that are inputs, because pin_out always carries the latch. A fault in the synchronizer depth or in the per-pin read select shows in the 0x02 readback two edges after the pin_in change. The bench sweeps all 32 direction patterns and all 256 addresses so that such faults appear at the ports.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned GP_NPINS     = 5;
    localparam int unsigned GP_AW        = 8;
    localparam int unsigned GP_DW        = 8;
    localparam int unsigned GP_DATA_ADDR = 2;
    localparam int unsigned GP_DIR_ADDR  = 6;
    localparam int unsigned GP_CKO_BIT   = 7;
    localparam int unsigned GP_CLK_PIN   = 2;
    localparam int unsigned GP_SYNC_LEN  = 2;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'd0,
        PM_OUTPUT = 2'd1,
        PM_CLOCK  = 2'd2
    } pin_mode_e;

    typedef enum logic {
        CKO_OFF   = 1'b0,
        CKO_DRIVE = 1'b1
    } cko_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W   = 5,
    parameter int unsigned LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage [LEN];

    genvar gs;
    generate
        for (gs = 0; gs < LEN; gs++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage[gs] <= '0;
                end else if (gs == 0) begin
                    stage[gs] <= d_async;
                end else begin
                    stage[gs] <= stage[(gs == 0) ? 0 : gs - 1];
                end
            end
        end
    endgenerate

    assign q_sync = stage[LEN-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned NPINS     = GP_NPINS,
    parameter int unsigned AW        = GP_AW,
    parameter int unsigned DW        = GP_DW,
    parameter int unsigned DATA_ADDR = GP_DATA_ADDR,
    parameter int unsigned DIR_ADDR  = GP_DIR_ADDR,
    parameter int unsigned CKO_BIT   = GP_CKO_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    input  logic [NPINS-1:0] rd_pins,
    output logic [NPINS-1:0] latch_q,
    output logic [NPINS-1:0] dir_q,
    output logic             ck_on,
    output logic [DW-1:0]    rd_data
);
    localparam logic [AW-1:0] DATA_A = AW'(DATA_ADDR);
    localparam logic [AW-1:0] DIR_A  = AW'(DIR_ADDR);

    logic       hit_data;
    logic       hit_dir;
    logic       wr_data;
    logic       wr_dir;
    cko_state_e cko_state;
    cko_state_e cko_next;

    assign hit_data = (addr == DATA_A);
    assign hit_dir  = (addr == DIR_A);
    assign wr_data  = wr_en && hit_data;
    assign wr_dir   = wr_en && hit_dir;

    // Output latch: deliberately without reset.
    always_ff @(posedge clk) begin
        if (wr_data) begin
            latch_q <= wdata[NPINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_dir) begin
            dir_q <= wdata[NPINS-1:0];
        end
    end

    // Clock-out state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cko_state <= CKO_OFF;
        end else begin
            cko_state <= cko_next;
        end
    end

    // Clock-out next state
    always_comb begin
        cko_next = cko_state;
        unique case (cko_state)
            CKO_OFF: begin
                if (wr_dir && wdata[CKO_BIT]) begin
                    cko_next = CKO_DRIVE;
                end
            end
            CKO_DRIVE: begin
                if (wr_dir && !wdata[CKO_BIT]) begin
                    cko_next = CKO_OFF;
                end
            end
            default: cko_next = CKO_OFF;
        endcase
    end

    assign ck_on = (cko_state == CKO_DRIVE);

    // Read decode
    always_comb begin
        rd_data = '0;
        if (hit_data) begin
            rd_data[NPINS-1:0] = rd_pins;
        end else if (hit_dir) begin
            rd_data[NPINS-1:0] = dir_q;
            rd_data[CKO_BIT]   = ck_on;
        end
    end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter int unsigned NPINS   = GP_NPINS,
    parameter int unsigned CLK_PIN = GP_CLK_PIN
) (
    input  logic             bus_clk,
    input  logic             ck_on,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] latch_q,
    input  logic [NPINS-1:0] sync_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] rd_pins
);
    genvar gp;
    generate
        for (gp = 0; gp < NPINS; gp++) begin : g_pin
            pin_mode_e mode;

            always_comb begin
                if ((gp == CLK_PIN) && ck_on) begin
                    mode = PM_CLOCK;
                end else if (dir_q[gp]) begin
                    mode = PM_OUTPUT;
                end else begin
                    mode = PM_INPUT;
                end
            end

            always_comb begin
                unique case (mode)
                    PM_OUTPUT: begin
                        pin_out[gp] = latch_q[gp];
                        pin_oe[gp]  = 1'b1;
                        rd_pins[gp] = latch_q[gp];
                    end
                    PM_CLOCK: begin
                        pin_out[gp] = bus_clk;
                        pin_oe[gp]  = 1'b1;
                        rd_pins[gp] = latch_q[gp];
                    end
                    default: begin
                        pin_out[gp] = latch_q[gp];
                        pin_oe[gp]  = 1'b0;
                        rd_pins[gp] = sync_in[gp];
                    end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_clkout_port.sv
module gpio_clkout_port
    import gpio_pkg::*;
#(
    parameter int unsigned NPINS     = GP_NPINS,
    parameter int unsigned AW        = GP_AW,
    parameter int unsigned DW        = GP_DW,
    parameter int unsigned DATA_ADDR = GP_DATA_ADDR,
    parameter int unsigned DIR_ADDR  = GP_DIR_ADDR,
    parameter int unsigned CKO_BIT   = GP_CKO_BIT,
    parameter int unsigned CLK_PIN   = GP_CLK_PIN,
    parameter int unsigned SYNC_LEN  = GP_SYNC_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic             ck_on;
    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] rd_pins;

    gpio_sync #(
        .W   (NPINS),
        .LEN (SYNC_LEN)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (sync_in)
    );

    gpio_regs #(
        .NPINS     (NPINS),
        .AW        (AW),
        .DW        (DW),
        .DATA_ADDR (DATA_ADDR),
        .DIR_ADDR  (DIR_ADDR),
        .CKO_BIT   (CKO_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rd_pins (rd_pins),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .ck_on   (ck_on),
        .rd_data (rd_data)
    );

    gpio_pin_mux #(
        .NPINS   (NPINS),
        .CLK_PIN (CLK_PIN)
    ) u_mux (
        .bus_clk (clk),
        .ck_on   (ck_on),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .sync_in (sync_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .rd_pins (rd_pins)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int unsigned NPINS     = GP_NPINS,
    parameter int unsigned AW        = GP_AW,
    parameter int unsigned DW        = GP_DW,
    parameter int unsigned DATA_ADDR = GP_DATA_ADDR,
    parameter int unsigned DIR_ADDR  = GP_DIR_ADDR,
    parameter int unsigned CKO_BIT   = GP_CKO_BIT,
    parameter int unsigned CLK_PIN   = GP_CLK_PIN
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    addr,
    input logic             wr_en,
    input logic [DW-1:0]    wdata,
    input logic [DW-1:0]    rd_data,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] dir_q,
    input logic             ck_on
);
    localparam logic [AW-1:0]    DATA_A = AW'(DATA_ADDR);
    localparam logic [AW-1:0]    DIR_A  = AW'(DIR_ADDR);
    localparam logic [NPINS-1:0] CK_M   = NPINS'(1) << CLK_PIN;

    logic [1:0] since_rst;
    logic       rst_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        rst_lo_q <= !rst_n;
    end

    always @(posedge clk) begin
        if (!rst_n && rst_lo_q) begin
            a_r4_reset_clears: assert (dir_q == '0 && !ck_on && pin_oe == '0)
                else $error("R4 reset state violated");
        end
    end

    a_r3_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_on |-> (pin_oe == dir_q));

    a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DIR_A) |=> (dir_q == $past(wdata[NPINS-1:0])));

    a_r5_cko_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DIR_A) |=> (ck_on == $past(wdata[CKO_BIT])));

    a_r6_clk_pin_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ck_on |-> (pin_oe[CLK_PIN] && ((pin_oe | CK_M) == (dir_q | CK_M))));

    a_r7_dir_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == DIR_A) |-> (rd_data[CKO_BIT-1:NPINS] == '0));

    a_r7_data_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == DATA_A) |-> (rd_data[DW-1:NPINS] == '0));

    a_r9_sync_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && addr == DATA_A)
        |-> (((rd_data[NPINS-1:0] ^ $past(pin_in, 2)) & ~pin_oe) == '0));

    a_r10_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != DATA_A && addr != DIR_A) |-> (rd_data == '0));
endmodule

bind gpio_clkout_port gpio_port_chk #(
    .NPINS     (NPINS),
    .AW        (AW),
    .DW        (DW),
    .DATA_ADDR (DATA_ADDR),
    .DIR_ADDR  (DIR_ADDR),
    .CKO_BIT   (CKO_BIT),
    .CLK_PIN   (CLK_PIN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_oe  (pin_oe),
    .dir_q   (dir_q),
    .ck_on   (ck_on)
);

// File: tb/test_gpio_clkout_port.sv
module test_gpio_clkout_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic       wr_en;
    logic [7:0] wdata;
    logic [7:0] rd_data;
    logic [4:0] pin_in;
    logic [4:0] pin_out;
    logic [4:0] pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_clkout_port i_gpio_clkout_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        logic [7:0] v;
        logic [4:0] lat;
        rst_n  = 1'b0;
        addr   = 8'h00;
        wr_en  = 1'b0;
        wdata  = 8'h00;
        pin_in = 5'h00;
        repeat (3) @(negedge clk);
        check("R4 oe in reset", 32'(pin_oe), 32'h0);
        rd(8'h06, v);
        check("R4 dir in reset", 32'(v), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reads of every other address return 0
        for (int a = 0; a < 256; a++) begin
            if (a != 2 && a != 6) begin
                rd(8'(a), v);
                check("R10 read other addr", 32'(v), 32'h0);
            end
        end

        // R1 R3 R8 R7: sweep all direction patterns
        for (int d = 0; d < 32; d++) begin
            lat = 5'(d) ^ 5'h0A;
            wr(8'h02, {3'b111, lat});
            wr(8'h06, {3'b011, 5'(d)});
            check("R3 oe follows dir", 32'(pin_oe), 32'(d));
            check("R1 pin_out latch", 32'(pin_out), 32'(lat));
            rd(8'h06, v);
            check("R3 R7 dir readback", 32'(v), 32'(d));
            @(negedge clk);
            pin_in = ~5'(d) ^ 5'(d * 7);
            repeat (3) @(negedge clk);
            rd(8'h02, v);
            check("R8 R7 data readback", 32'(v),
                  32'((lat & 5'(d)) | (pin_in & ~5'(d))));
        end

        // R9: two-edge synchronizer latency
        wr(8'h06, 8'h00);
        @(negedge clk);
        pin_in = 5'h00;
        repeat (3) @(negedge clk);
        pin_in = 5'h1F;
        rd(8'h02, v);
        check("R9 no change before edge", 32'(v), 32'h00);
        @(negedge clk);
        rd(8'h02, v);
        check("R9 no change after one edge", 32'(v), 32'h00);
        @(negedge clk);
        rd(8'h02, v);
        check("R9 visible after two edges", 32'(v), 32'h1F);

        // R5 R6: clock out on pin 2
        wr(8'h02, 8'h00);
        wr(8'h06, 8'h80);
        check("R6 clk pin oe", 32'(pin_oe), 32'h04);
        rd(8'h06, v);
        check("R5 enable readback", 32'(v), 32'h80);
        check("R6 pin2 low phase", 32'(pin_out[2]), 32'h0);
        @(posedge clk);
        #5;
        check("R6 pin2 high phase", 32'(pin_out[2]), 32'h1);
        check("R6 other pins latch", 32'(pin_out & 5'h1B), 32'h00);
        @(negedge clk);
        rd(8'h02, v);
        check("R8 clock pin reads latch", 32'(v), 32'h1B);
        wr(8'h06, 8'h9B);
        check("R6 dir2 zero no effect", 32'(pin_oe), 32'h1F);
        wr(8'h06, 8'h84);
        check("R6 dir2 one", 32'(pin_oe), 32'h04);
        wr(8'h06, 8'hFF);
        rd(8'h06, v);
        check("R7 R5 dir all ones", 32'(v), 32'h9F);
        wr(8'h06, 8'h00);
        rd(8'h06, v);
        check("R5 enable cleared", 32'(v), 32'h00);
        check("R6 clock released", 32'(pin_oe), 32'h00);

        // R10: writes elsewhere change nothing
        wr(8'h02, 8'h0C);
        wr(8'h06, 8'h13);
        for (int a = 0; a < 256; a++) begin
            if (a != 2 && a != 6) begin
                wr(8'(a), 8'hFF);
            end
        end
        rd(8'h06, v);
        check("R10 dir unchanged", 32'(v), 32'h13);
        check("R10 oe unchanged", 32'(pin_oe), 32'h13);
        check("R10 latch unchanged", 32'(pin_out), 32'h0C);

        // R2 R4: reset keeps latch, clears direction
        wr(8'h06, 8'h9F);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R4 oe cleared by reset", 32'(pin_oe), 32'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 latch kept over reset", 32'(pin_out), 32'h0C);
        rd(8'h06, v);
        check("R4 dir and enable cleared", 32'(v), 32'h00);
        wr(8'h06, 8'h1F);
        check("R2 latch drives after reset", 32'(pin_out), 32'h0C);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule